// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block steps through a fixed control store of micro-orders, one micro-order per clock. Each stored word holds a field of arithmetic-unit control bits, a field of control-register-unit control bits, an optional instruction to load one of two condition flip-flops from a chosen status digit, an optional condition test on one flip-flop, a dispatch marker, and two next-address fields. The block holds the micro-address register and the two condition flip-flops. It presents the control bits of the current micro-order on its outputs.

A fetch routine occupies micro-addresses 0 to 4. Its last entry dispatches on the five-bit opcode of the fetched order into one execution routine per machine order, at micro-addresses 5 to 15. A conditional micro-order picks its second address field when the named flip-flop holds 1 and its first when it holds 0. A flip-flop loaded by a micro-order takes its new value at the end of that step, so a test in the same micro-order sees the previous value. Undefined opcodes lead to a halt entry that loops on itself until reset. The datapath registers themselves are outside this block. Only their status digits enter it.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset sets the micro-address to 0 and clears both condition flip-flops. condFlags bit 0 is flip-flop 0 and bit 1 is flip-flop 1.
- R2: From micro-address 0 the block visits 0, 1, 2, 3 and 4 on consecutive clocks, whatever the status digits and flip-flops hold.
- R3: At micro-address 4 an opcode k in the range 0 to 10 sends control to micro-address 5+k on the next clock.
- R4: At micro-address 4 an opcode of 11 or more sends control to micro-address 31. Micro-address 31 repeats on every clock until reset.
- R5: An unconditional micro-order goes to its first address field, whatever the flip-flops hold. Entries 5, 6, 7, 9, 11, 13, 14, 15, 17, 18 and 21 return to 0. Entry 8 goes to 16, entry 10 goes to 19 and entry 12 goes to 20.
- R6: A conditional micro-order goes to its second address field when its flip-flop is 1 and to its first when it is 0. Entry 16 tests flip-flop 0 and goes to 17 or 18. Entry 20 tests flip-flop 0 and goes to 0 or 21. Entry 19 tests flip-flop 1 and goes to 19 or 0.
- R7: Entry 8 loads flip-flop 0 from status bit 2. Entry 12 loads flip-flop 0 from status bit 0. Entries 10 and 19 load flip-flop 1 from status bit 1. The loaded value appears on the next clock.
- R8: When a micro-order both loads and tests the same flip-flop (entry 19), the test uses the value held before that step's load.
- R9: A flip-flop keeps its value in every step that does not load it, whatever the status digits do.
- R10: microAddr shows the current micro-address. aluCtl holds that address zero-extended and regCtl holds its bitwise complement, so each step's control word is unique.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous reset / start |
| statusIn | input | 4 | Status digits from the datapath registers |
| opcode | input | 5 | Function field of the fetched order |
| aluCtl | output | 8 | Arithmetic-unit control bits of the current micro-order |
| regCtl | output | 8 | Control-register-unit control bits of the current micro-order |
| microAddr | output | 5 | Current micro-address |
| condFlags | output | 2 | Condition flip-flops, bit 0 is flip-flop 0 |

## Verification
The bench builds the block with its default parameters: a 5-bit micro-address (32 entries), a 5-bit opcode, four status digits and 8-bit control fields. With these values both dispatch edges are reachable, opcode 10 landing on entry 15 and opcode 11 falling to the halt entry. Every conditional entry is driven down both of its arms. Entry 19, which loads and tests the same flip-flop, is run with its status digit changed during the step so that the old-value rule shows in the address sequence.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W     = 5;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int OP_W       = 5;
  localparam int STAT_N     = 4;
  localparam int SRC_W      = $clog2(STAT_N);
  localparam int ALU_W      = 8;
  localparam int REG_W      = 8;
  localparam int NUM_OPS    = 11;
  localparam int EXEC_BASE  = 5;
  localparam int FETCH_LAST = 4;
  localparam int HALT_ADDR  = DEPTH - 1;

  // Strobes from the sequencer control to the flag datapath
  typedef struct packed {
    logic             setEn;
    logic             setSel;
    logic [SRC_W-1:0] setSrc;
  } flagStrobe_t;

  typedef struct packed {
    logic [ALU_W-1:0]  aluF;
    logic [REG_W-1:0]  regF;
    flagStrobe_t       setF;
    logic              condEn;
    logic              condSel;
    logic              dispatch;
    logic [ADDR_W-1:0] addr0;
    logic [ADDR_W-1:0] addr1;
  } uWord_t;

  // Builds one control-store entry from its micro-address
  function automatic uWord_t makeWord(input int a);
    uWord_t w;
    w       = '0;
    w.aluF  = ALU_W'(a);
    w.regF  = ~REG_W'(a);
    w.addr0 = ADDR_W'(HALT_ADDR);
    case (a)
      0, 1, 2, 3: w.addr0 = ADDR_W'(a + 1);
      4:          w.dispatch = 1'b1;
      5, 6, 7, 9, 11, 13, 14, 15, 17, 18, 21: w.addr0 = '0;
      8: begin
        w.setF  = '{setEn: 1'b1, setSel: 1'b0, setSrc: SRC_W'(2)};
        w.addr0 = ADDR_W'(16);
      end
      10: begin
        w.setF  = '{setEn: 1'b1, setSel: 1'b1, setSrc: SRC_W'(1)};
        w.addr0 = ADDR_W'(19);
      end
      12: begin
        w.setF  = '{setEn: 1'b1, setSel: 1'b0, setSrc: SRC_W'(0)};
        w.addr0 = ADDR_W'(20);
      end
      16: begin
        w.condEn  = 1'b1;
        w.condSel = 1'b0;
        w.addr0   = ADDR_W'(17);
        w.addr1   = ADDR_W'(18);
      end
      19: begin
        w.setF    = '{setEn: 1'b1, setSel: 1'b1, setSrc: SRC_W'(1)};
        w.condEn  = 1'b1;
        w.condSel = 1'b1;
        w.addr0   = ADDR_W'(19);
        w.addr1   = '0;
      end
      20: begin
        w.condEn  = 1'b1;
        w.condSel = 1'b0;
        w.addr0   = '0;
        w.addr1   = ADDR_W'(21);
      end
      default: w.addr0 = ADDR_W'(HALT_ADDR);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW    = useq_pkg::ADDR_W,
  parameter int DEPTH = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output uWord_t        word
);

  uWord_t romArr [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign romArr[i] = makeWord(i);
    end
  endgenerate

  assign word = romArr[addr];

endmodule

// File: rtl/useq_flags.sv
module useq_flags
  import useq_pkg::*;
#(
  parameter int SN = useq_pkg::STAT_N
) (
  input  logic          clk,
  input  logic          rst,
  input  flagStrobe_t   strobe,
  input  logic [SN-1:0] status,
  output logic [1:0]    flags
);

  logic [1:0] flagQ;
  logic       pick;

  assign pick = status[strobe.setSrc];

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
    end else begin
      for (int f = 0; f < 2; f++) begin
        if (strobe.setEn && (strobe.setSel == 1'(f))) flagQ[f] <= pick;
      end
    end
  end

  assign flags = flagQ;

  // R7: the named flip-flop takes the chosen status digit
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    strobe.setEn |=> flags[$past(strobe.setSel)] == $past(status[strobe.setSrc]));

  // R9: no load strobe leaves both flip-flops untouched
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.setEn |=> $stable(flags));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int AW    = useq_pkg::ADDR_W,
  parameter int OW    = useq_pkg::OP_W,
  parameter int NOPS  = useq_pkg::NUM_OPS,
  parameter int EBASE = useq_pkg::EXEC_BASE
) (
  input  logic          clk,
  input  logic          rst,
  input  uWord_t        word,
  input  logic [OW-1:0] opcode,
  input  logic [1:0]    flags,
  output logic [AW-1:0] upc,
  output flagStrobe_t   strobe
);

  localparam logic [AW-1:0] HALT  = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] FLAST = AW'(FETCH_LAST);

  logic [AW-1:0] upcQ;
  logic [AW-1:0] nextAddr;
  logic [AW-1:0] dispAddr;
  logic          opValid;
  logic          condBit;

  assign opValid  = opcode < OW'(NOPS);
  assign dispAddr = opValid ? (AW'(EBASE) + AW'(opcode)) : HALT;
  assign condBit  = flags[word.condSel];

  always_comb begin
    if (word.dispatch)                 nextAddr = dispAddr;
    else if (word.condEn && condBit)   nextAddr = word.addr1;
    else                               nextAddr = word.addr0;
  end

  always_ff @(posedge clk) begin
    if (rst) upcQ <= '0;
    else     upcQ <= nextAddr;
  end

  assign upc    = upcQ;
  assign strobe = word.setF;

  // R2: fetch entries step forward by one
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (upcQ < FLAST) |=> upcQ == $past(upcQ) + AW'(1));

  // R3: a defined opcode enters its execution routine
  a_r3_dispatch: assert property (@(posedge clk) disable iff (rst)
    (word.dispatch && opcode < OW'(NOPS)) |=> upcQ == AW'(EBASE) + AW'($past(opcode)));

  // R4: an undefined opcode goes to the halt entry
  a_r4_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    (word.dispatch && opcode >= OW'(NOPS)) |=> upcQ == HALT);

  // R4: the halt entry holds until reset
  a_r4_halt_loop: assert property (@(posedge clk) disable iff (rst)
    (upcQ == HALT) |=> upcQ == HALT);

  // R5: unconditional orders follow the first address field
  a_r5_uncond: assert property (@(posedge clk) disable iff (rst)
    (!word.condEn && !word.dispatch) |=> upcQ == $past(word.addr0));

  // R6 and R8: conditional orders follow the flip-flop value held during the step
  a_r6_cond: assert property (@(posedge clk) disable iff (rst)
    (word.condEn && !word.dispatch) |=>
      upcQ == ($past(flags[word.condSel]) ? $past(word.addr1) : $past(word.addr0)));

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW = useq_pkg::ADDR_W,
  parameter int OW = useq_pkg::OP_W,
  parameter int SN = useq_pkg::STAT_N,
  parameter int AL = useq_pkg::ALU_W,
  parameter int RG = useq_pkg::REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SN-1:0] statusIn,
  input  logic [OW-1:0] opcode,
  output logic [AL-1:0] aluCtl,
  output logic [RG-1:0] regCtl,
  output logic [AW-1:0] microAddr,
  output logic [1:0]    condFlags
);

  uWord_t        word;
  flagStrobe_t   strobe;
  logic [AW-1:0] upc;
  logic [1:0]    flags;

  useq_store #(.AW(AW)) u_store (
    .addr (upc),
    .word (word)
  );

  useq_ctrl #(.AW(AW), .OW(OW), .NOPS(NUM_OPS), .EBASE(EXEC_BASE)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .word   (word),
    .opcode (opcode),
    .flags  (flags),
    .upc    (upc),
    .strobe (strobe)
  );

  useq_flags #(.SN(SN)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .status (statusIn),
    .flags  (flags)
  );

  assign aluCtl    = AL'(word.aluF);
  assign regCtl    = RG'(word.regF);
  assign microAddr = upc;
  assign condFlags = flags;

endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst;
  logic [3:0] statusIn;
  logic [4:0] opcode;
  logic [7:0] aluCtl;
  logic [7:0] regCtl;
  logic [4:0] microAddr;
  logic [1:0] condFlags;

  int checks = 0;
  int errors = 0;

  logic [6:0] expQ[$];
  string      tagQ[$];

  useq_top dut (
    .clk       (clk),
    .rst       (rst),
    .statusIn  (statusIn),
    .opcode    (opcode),
    .aluCtl    (aluCtl),
    .regCtl    (regCtl),
    .microAddr (microAddr),
    .condFlags (condFlags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Monitor: compares each expected step against the outputs
  always @(negedge clk) begin
    logic [6:0] e;
    string      tg;
    if (expQ.size() > 0) begin
      e  = expQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if ({condFlags, microAddr} !== e) begin
        errors++;
        $display("FAIL %s flags/addr actual %b/%0d expected %b/%0d",
                 tg, condFlags, microAddr, e[6:5], e[4:0]);
      end else if (aluCtl !== {3'b000, e[4:0]} || regCtl !== ~{3'b000, e[4:0]}) begin
        errors++;
        $display("FAIL R10 at %0d alu/reg actual %h/%h expected %h/%h",
                 e[4:0], aluCtl, regCtl, {3'b000, e[4:0]}, ~{3'b000, e[4:0]});
      end
    end
  end

  // Driver: queue the expected step, then drive inputs for the next edge
  task automatic cyc(input logic [4:0] ea, input logic [1:0] ef, input string tg,
                     input logic r, input logic [3:0] st, input logic [4:0] op);
    expQ.push_back({ef, ea});
    tagQ.push_back(tg);
    @(negedge clk);
    #1;
    rst      = r;
    statusIn = st;
    opcode   = op;
  endtask

  task automatic fetch(input logic [1:0] ef, input logic [4:0] op, input logic [3:0] st);
    for (int a = 0; a <= 4; a++) cyc(5'(a), ef, "R2", 1'b0, st, op);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; statusIn = '0; opcode = '0;
    cyc(5'd0, 2'b00, "R1", 1'b1, 4'h0, 5'd0);

    // add order, status noise during fetch does not touch flags (R9)
    fetch(2'b00, 5'd0, 4'hF);
    cyc(5'd5, 2'b00, "R3 R9", 1'b0, 4'hF, 5'd0);

    // multiply entry, status bit 2 = 1 -> R6 second arm
    fetch(2'b00, 5'd3, 4'h0);
    cyc(5'd8,  2'b00, "R3", 1'b0, 4'b0100, 5'd3);
    cyc(5'd16, 2'b01, "R7", 1'b0, 4'h0, 5'd3);
    cyc(5'd18, 2'b01, "R6", 1'b0, 4'h0, 5'd3);

    // multiply entry, only bit 0 set: flip-flop 0 must load 0 from bit 2
    fetch(2'b01, 5'd3, 4'h0);
    cyc(5'd8,  2'b01, "R3", 1'b0, 4'b0001, 5'd3);
    cyc(5'd16, 2'b00, "R7", 1'b0, 4'h0, 5'd3);
    cyc(5'd17, 2'b00, "R6", 1'b0, 4'h0, 5'd3);

    // shift entry: entry 19 tests the old flip-flop 1 (R8)
    fetch(2'b00, 5'd5, 4'h0);
    cyc(5'd10, 2'b00, "R3", 1'b0, 4'b0000, 5'd5);
    cyc(5'd19, 2'b00, "R8", 1'b0, 4'b0010, 5'd5);
    cyc(5'd19, 2'b10, "R8", 1'b0, 4'b0000, 5'd5);

    // branch-negative entry, both arms of entry 20
    fetch(2'b00, 5'd7, 4'h0);
    cyc(5'd12, 2'b00, "R3", 1'b0, 4'b0001, 5'd7);
    cyc(5'd20, 2'b01, "R6", 1'b0, 4'h0, 5'd7);
    cyc(5'd21, 2'b01, "R5", 1'b0, 4'h0, 5'd7);
    fetch(2'b01, 5'd7, 4'h0);
    cyc(5'd12, 2'b01, "R3", 1'b0, 4'b0000, 5'd7);
    cyc(5'd20, 2'b00, "R6", 1'b0, 4'h0, 5'd7);

    // set both flip-flops
    fetch(2'b00, 5'd5, 4'h0);
    cyc(5'd10, 2'b00, "R3", 1'b0, 4'b0010, 5'd5);
    cyc(5'd19, 2'b10, "R6", 1'b0, 4'b0010, 5'd5);
    fetch(2'b10, 5'd3, 4'h0);
    cyc(5'd8,  2'b10, "R3", 1'b0, 4'b0100, 5'd3);
    cyc(5'd16, 2'b11, "R7", 1'b0, 4'h0, 5'd3);
    cyc(5'd18, 2'b11, "R5", 1'b0, 4'h0, 5'd3);

    // highest defined opcode and an unconditional order with flags set
    fetch(2'b11, 5'd10, 4'hF);
    cyc(5'd15, 2'b11, "R3 R5", 1'b0, 4'hF, 5'd0);
    fetch(2'b11, 5'd0, 4'hF);
    cyc(5'd5, 2'b11, "R5", 1'b0, 4'hF, 5'd11);

    // first undefined opcode, halt loop, then reset
    fetch(2'b11, 5'd11, 4'h0);
    cyc(5'd31, 2'b11, "R4", 1'b0, 4'hF, 5'd0);
    cyc(5'd31, 2'b11, "R4", 1'b0, 4'hF, 5'd0);
    cyc(5'd31, 2'b11, "R4", 1'b1, 4'h0, 5'd31);
    cyc(5'd0,  2'b00, "R1", 1'b0, 4'h0, 5'd31);
    for (int a = 1; a <= 4; a++) cyc(5'(a), 2'b00, "R2", 1'b0, 4'h0, 5'd31);
    cyc(5'd31, 2'b00, "R4", 1'b0, 4'h0, 5'd31);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule